// File: doc/BRIEF.md
# Clocked Phase-Frequency Detector with Pump Control

This block decides, cycle by cycle, how a charge pump should steer a loop filter in a phase-locked loop. It takes a one-cycle strobe from the reference divider and a one-cycle strobe from the main (VCO) divider. When the reference strobe comes first, the source control `pump_up` is raised. When the main strobe comes first, the sink control `pump_dn` is raised. The leading control stays high until the other strobe arrives. Both controls then stay high together for a fixed overlap window of `OVL` cycles, after which the detector clears. Because of this overlap, an arbitrarily small phase error still produces a complete, measurable pulse pair, and the detector has no dead zone.

A pump current magnitude code is registered and passed on to the analog pump. A power-down request takes effect only while both controls are low, so a pulse that has started always runs to its end. While the block is powered down, both controls stay low and divider strobes are ignored. When the request is released, the detector returns to its idle state, ready for the next pair of strobes.

Top module: `pump_pfd`

## Requirements
- R1: A `ref_stb` pulse accepted while the detector is idle raises `pump_up` in the cycle after it is sampled, and `pump_up` stays high until the detector clears.
- R2: A `main_stb` pulse accepted while the detector is idle raises `pump_dn` in the cycle after it is sampled, and `pump_dn` stays high until the detector clears.
- R3: With strobes `d` cycles apart, the leading control is high for `d + OVL` cycles and the trailing control for `OVL` cycles, so the pulse is never shorter than the arrival gap.
- R4: Once both controls are high, they stay high together for exactly `OVL` cycles and then both fall in the same cycle. Coincident strobes give two `OVL`-wide pulses.
- R5: Strobes that arrive while both controls are high, including the clearing cycle, have no effect and do not start a new pulse.
- R6: `cur_code_o` equals the value `cur_code` had one cycle earlier, for every code value.
- R7: A power-down request raises `pd_stat` only in a cycle where both controls were low. A strobe sampled in the same cycle as that entry is ignored.
- R8: While `pd_stat` is high, `pump_up` and `pump_dn` are low and divider strobes are ignored.
- R9: Dropping `pd_req` clears `pd_stat` one cycle later with both controls low, and the next strobe pair behaves as it would from reset.
- R10: During and after reset, `pump_up`, `pump_dn` and `pd_stat` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe from the reference divider |
| main_stb | input | 1 | One-cycle strobe from the main divider |
| cur_code | input | CODE_W | Pump current magnitude, in units of the base current |
| pd_req | input | 1 | Power-down request, level sensitive |
| pump_up | output | 1 | Source control to the charge pump |
| pump_dn | output | 1 | Sink control to the charge pump |
| cur_code_o | output | CODE_W | Registered current magnitude for the pump |
| pd_stat | output | 1 | High while the detector is powered down |

## Verification
The hardest case to reach from the ports is a power-down request that arrives in the middle of a long one-sided pulse. The request must be held off until the overlap finishes. The bench reaches it by raising `pd_req` a few cycles after a reference strobe and delaying the main strobe further. It then checks that the pulse widths are unchanged and that `pd_stat` never overlaps an active control. Strobes that land inside the overlap window are placed on both its first and its clearing cycle. The full grid of arrival offsets is swept, and the widths are compared with the values computed from `OVL`.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int OVL_CNT_W = 8;
    typedef logic [OVL_CNT_W-1:0] ovl_cnt_t;

    typedef struct packed {
        ovl_cnt_t cnt;
    } ovl_state_t;

    typedef struct packed {
        logic down;
    } pwr_state_t;
endpackage

// File: rtl/pfd_arm.sv
module pfd_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic hold_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i)
            flag_d = 1'b0;
        else if (edge_i && !hold_i)
            flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R1
    arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(edge_i && !hold_i));
endmodule

// File: rtl/pfd_overlap.sv
module pfd_overlap
    import pfd_pkg::*;
#(
    parameter int OVL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    output logic clr_o
);
    localparam ovl_cnt_t LAST = ovl_cnt_t'(OVL - 1);

    ovl_state_t s_d, s_q;
    logic both;

    assign both  = up_i && dn_i;
    assign clr_o = both && (s_q.cnt == LAST);

    always_comb begin
        s_d = s_q;
        if (!both)
            s_d.cnt = '0;
        else if (s_q.cnt == LAST)
            s_d.cnt = '0;
        else
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    initial ovl_param_chk: assert (OVL >= 1 && OVL < (1 << OVL_CNT_W));

    // R4
    ovl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST);

    // R4
    ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both && !clr_o) |=> (up_i && dn_i));
endmodule

// File: rtl/pfd_power.sv
module pfd_power
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic idle_i,
    output logic down_o,
    output logic enter_o
);
    pwr_state_t s_d, s_q;

    assign enter_o = !s_q.down && req_i && idle_i;

    always_comb begin
        s_d = s_q;
        if (s_q.down)
            s_d.down = req_i;
        else
            s_d.down = req_i && idle_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign down_o = s_q.down;

    // R7
    pwr_idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.down) |-> $past(idle_i && req_i));

    // R9
    pwr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.down) |-> $past(!req_i));
endmodule

// File: rtl/pump_pfd.sv
module pump_pfd #(
    parameter int OVL    = 2,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_stb,
    input  logic              main_stb,
    input  logic [CODE_W-1:0] cur_code,
    input  logic              pd_req,
    output logic              pump_up,
    output logic              pump_dn,
    output logic [CODE_W-1:0] cur_code_o,
    output logic              pd_stat
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0] stb;
    logic [NSIDE-1:0] flag;
    logic             clr, down, enter, hold, idle;
    logic [CODE_W-1:0] code_d, code_q;

    assign stb  = {main_stb, ref_stb};
    assign hold = down || enter;
    assign idle = (flag == '0);

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        pfd_arm u_arm (
            .clk    (clk),
            .rst_n  (rst_n),
            .edge_i (stb[i]),
            .hold_i (hold),
            .clr_i  (clr),
            .flag_o (flag[i])
        );
    end

    pfd_overlap #(.OVL(OVL)) u_ovl (
        .clk   (clk),
        .rst_n (rst_n),
        .up_i  (flag[0]),
        .dn_i  (flag[1]),
        .clr_o (clr)
    );

    pfd_power u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pd_req),
        .idle_i  (idle),
        .down_o  (down),
        .enter_o (enter)
    );

    always_comb code_d = cur_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign pump_up    = flag[0];
    assign pump_dn    = flag[1];
    assign cur_code_o = code_q;
    assign pd_stat    = down;

    // R8
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_stat |-> (!pump_up && !pump_dn));

    // R3
    up_no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_up) |-> $past(pump_dn));

    // R3
    dn_no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_dn) |-> $past(pump_up));

    // R4
    joint_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_up) |-> $fell(pump_dn));
endmodule

// File: tb/pump_pfd_bench.sv
`timescale 1ns/1ps
module pump_pfd_bench;
    localparam int OVL    = 2;
    localparam int CODE_W = 5;
    localparam int WIN    = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_stb = 1'b0, main_stb = 1'b0, pd_req = 1'b0;
    logic [CODE_W-1:0] cur_code = '0;
    logic pump_up, pump_dn, pd_stat;
    logic [CODE_W-1:0] cur_code_o;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pump_pfd #(.OVL(OVL), .CODE_W(CODE_W)) u_pump_pfd (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .main_stb(main_stb),
        .cur_code(cur_code), .pd_req(pd_req), .pump_up(pump_up),
        .pump_dn(pump_dn), .cur_code_o(cur_code_o), .pd_stat(pd_stat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    // ref strobe at iteration tr, main at tm, extra ref at xr, pd_req from pdf
    task automatic run_pair(input int tr, input int tm, input int xr, input int pdf,
                            output int us, output int ds, output int uw,
                            output int dw, output int pdbad);
        us = -1; ds = -1; uw = 0; dw = 0; pdbad = 0;
        for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            if (pump_up) begin uw++; if (us < 0) us = c; end
            if (pump_dn) begin dw++; if (ds < 0) ds = c; end
            if (pd_stat && (pump_up || pump_dn)) pdbad++;
            ref_stb  = (c == tr) || (c == xr);
            main_stb = (c == tm);
            pd_req   = (pdf >= 0) && (c >= pdf);
        end
        ref_stb = 1'b0; main_stb = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        nchk++; nbad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int us, ds, uw, dw, pb, m;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!pump_up && !pump_dn && !pd_stat, "R10", {pump_up, pump_dn, pd_stat}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pump_up && !pump_dn && !pd_stat, "R10", {pump_up, pump_dn, pd_stat}, 0);

        // R1 R2 R3 R4 grid sweep of arrival offsets
        for (int tr = 0; tr < 7; tr++) begin
            for (int tm = 0; tm < 7; tm++) begin
                run_pair(tr, tm, -1, -1, us, ds, uw, dw, pb);
                m = (tr > tm) ? tr : tm;
                chk(us == tr + 1, "R1", us, tr + 1);
                chk(ds == tm + 1, "R2", ds, tm + 1);
                chk(uw == m - tr + OVL, "R3", uw, m - tr + OVL);
                chk(dw == m - tm + OVL, "R4", dw, m - tm + OVL);
            end
        end

        // R5 strobe on first overlap cycle and on clearing cycle
        run_pair(3, 3, 4, -1, us, ds, uw, dw, pb);
        chk(uw == OVL, "R5", uw, OVL);
        run_pair(3, 3, 3 + OVL, -1, us, ds, uw, dw, pb);
        chk(uw == OVL, "R5", uw, OVL);
        chk(dw == OVL, "R5", dw, OVL);

        // R7 power-down requested mid-pulse must not cut it
        run_pair(0, 5, -1, 2, us, ds, uw, dw, pb);
        chk(uw == 5 + OVL, "R7", uw, 5 + OVL);
        chk(dw == OVL, "R7", dw, OVL);
        chk(pb == 0, "R7", pb, 0);
        chk(pd_stat == 1'b1, "R7", pd_stat, 1);

        // R8 strobes ignored while powered down
        @(negedge clk); ref_stb = 1'b1;
        @(negedge clk); ref_stb = 1'b0; main_stb = 1'b1;
        @(negedge clk); main_stb = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk(!pump_up && !pump_dn && pd_stat, "R8", {pump_up, pump_dn, pd_stat}, 1);
            @(negedge clk);
        end

        // R9 release and re-arm
        pd_req = 1'b0;
        @(negedge clk);
        chk(!pd_stat && !pump_up && !pump_dn, "R9", {pump_up, pump_dn, pd_stat}, 0);
        run_pair(1, 3, -1, -1, us, ds, uw, dw, pb);
        chk(us == 2 && uw == 2 + OVL, "R9", uw, 2 + OVL);
        chk(ds == 4 && dw == OVL, "R9", dw, OVL);

        // R7 entry from idle with a coincident strobe: strobe ignored
        @(negedge clk); pd_req = 1'b1; ref_stb = 1'b1;
        @(negedge clk); ref_stb = 1'b0;
        chk(pd_stat && !pump_up, "R7", {pd_stat, pump_up}, 2);
        @(negedge clk);
        chk(!pump_up, "R8", pump_up, 0);
        pd_req = 1'b0;
        @(negedge clk);
        chk(!pd_stat, "R9", pd_stat, 0);

        // R6 all code values
        for (int v = 0; v < (1 << CODE_W); v++) begin
            cur_code = CODE_W'(v);
            @(negedge clk);
            chk(cur_code_o == CODE_W'(v), "R6", cur_code_o, v);
        end

        done = 1'b1;
        summary();
    end
endmodule